// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block takes one asynchronous serial line and turns each character on it into a parallel byte. A divider outside the block supplies a tick at sixteen times the bit rate. Each tick samples the line, which can be inverted first. A start edge is accepted only if the line is still low half a bit later. The data bits are then taken at their bit centres, least significant bit first. After them come an optional parity bit and one stop bit. The frame format is set by four static controls: 7- or 8-bit characters, parity on or off, odd or even parity, and line inversion.

Each finished character goes from the shift register into a separate holding register, so the next character can start shifting in at once. Four sticky flags report the result of each character: ready, overrun, framing and parity. The host has three strobes. One reads the data, one reads the flags, and one writes a clear mask. A flag clears on a mask bit of 0 only if the flag was 1 when the host last read the flags. While any error flag is set, the receiver accepts no more characters, so the host has to deal with the error before reception starts again.

Top module: `serial_rx_unit`

## Requirements
- R1: Each tick samples the line. A start bit counts only if the line is still low eight ticks after the first low sample. A low pulse shorter than that changes nothing. Data bits are sampled every sixteen ticks after that point, least significant bit first.
- R2: With `cfg_short_i`=1 a character has 7 data bits and bit 7 of the stored byte is 0. With `cfg_short_i`=0 it has 8 data bits.
- R3: With `cfg_par_en_i`=1 a parity bit follows the data. With `cfg_par_odd_i`=0 the number of ones in the data and parity bits together must be even; with `cfg_par_odd_i`=1 it must be odd. Otherwise status bit 3 (parity) is set. With `cfg_par_en_i`=0 no parity bit is expected or checked.
- R4: Only the first stop bit is checked. If it is low, status bit 2 (framing) is set, the byte is still stored, and status bit 0 is not set.
- R5: A start bit that follows a stop bit directly is received as the next character. A low second stop bit therefore begins a new character.
- R6: A character with no error, received while status bit 0 is clear, is stored in `rx_data_o` and sets status bit 0 (ready).
- R7: Status bit 0 clears on a `host_rd_data_i` strobe. It also clears on a write with `host_wr_val_i[0]`=0 if it read as 1 on an earlier `host_rd_stat_i` strobe.
- R8: If a character completes while status bit 0 is 1, status bit 1 (overrun) is set, `rx_data_o` keeps its old value and the new character is lost.
- R9: A character with a parity error is still stored in `rx_data_o`, and status bit 0 is not set.
- R10: While any of status bits 1 to 3 is set, no character is received: no flag is set and `rx_data_o` does not change.
- R11: Status bits 1 to 3 clear only on a write with the matching `host_wr_val_i` bit at 0, and only if that bit read as 1 on an earlier status read. A write of 0 with no earlier read has no effect.
- R12: While `rx_en_i`=0, characters on the line are ignored, and `rx_data_o` and all status bits keep their values.
- R13: With `cfg_invert_i`=1 the line is inverted before sampling, so the idle level is low and all bit values are complemented.
- R14: After reset `rx_data_o` is 0x00 and all status bits are 0. The host has no way to write `rx_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line_i | input | 1 | Serial input line |
| rx_en_i | input | 1 | Receive enable |
| cfg_short_i | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| cfg_invert_i | input | 1 | Invert the line before sampling |
| baud_tick_i | input | 1 | One-cycle tick at 16x the bit rate |
| host_rd_data_i | input | 1 | Host reads the data register |
| host_rd_stat_i | input | 1 | Host reads the status flags |
| host_wr_stat_i | input | 1 | Host writes the status clear mask |
| host_wr_val_i | input | 4 | Clear mask: a bit at 0 clears that flag |
| rx_data_o | output | DATA_W | Holding register |
| rx_status_o | output | 4 | Status flags: bit 0 ready, bit 1 overrun, bit 2 framing, bit 3 parity |

## Verification
The assertions check these rules on every cycle:
- The holding register changes only in the cycle after a character completes, and it does not change when overrun rises.
- Ready never rises while an error flag is set.
- Each flag falls only after a matching clear strobe.
- The framer leaves idle only when reception was allowed in the cycle before.

Other behaviour can be shown only by the bench's scenarios, where a behavioural model tracks the flags and data across whole characters:
- where the bits are sampled and glitch rejection;
- parity polarity;
- the 7-bit mask;
- back-to-back characters;
- line inversion.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   localparam int NUM_FLAGS = 4;
   localparam int FLAG_RDY  = 0;
   localparam int FLAG_OVR  = 1;
   localparam int FLAG_FRM  = 2;
   localparam int FLAG_PAR  = 3;

endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic invert_i,
   output logic line_o
);

   logic pol_line;
   assign pol_line = line_i ^ invert_i;

   generate
      if (STAGES == 0) begin : g_direct
         assign line_o = pol_line;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= (chain_q << 1) | STAGES'(pol_line);
         end
         assign line_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              line_i,
   input  logic              run_i,
   input  logic              short_i,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              stop_ok_o,
   output logic              par_ok_o
);

   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int BIT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] MID_C = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] END_C = CNT_W'(OVERSAMPLE - 1);

   rx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BIT_W-1:0]  bits_q;
   logic [DATA_W-1:0] shreg_q;
   logic              par_bit_q;
   logic              stop_bit_q;
   logic              done_q;
   logic [BIT_W-1:0]  last_bit;
   logic              at_end;

   assign last_bit = short_i ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);
   assign at_end   = (cnt_q == END_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         bits_q     <= '0;
         shreg_q    <= '0;
         par_bit_q  <= 1'b0;
         stop_bit_q <= 1'b1;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!run_i) begin
            state_q <= ST_IDLE;
         end else if (tick_i) begin
            unique case (state_q)
               ST_IDLE: begin
                  if (!line_i) begin
                     state_q <= ST_START;
                     cnt_q   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt_q == MID_C) begin
                     cnt_q   <= '0;
                     bits_q  <= '0;
                     state_q <= line_i ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (at_end) begin
                     cnt_q   <= '0;
                     shreg_q <= {line_i, shreg_q[DATA_W-1:1]};
                     bits_q  <= bits_q + 1'b1;
                     if (bits_q == last_bit)
                        state_q <= par_en_i ? ST_PAR : ST_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (at_end) begin
                     cnt_q     <= '0;
                     par_bit_q <= line_i;
                     state_q   <= ST_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (at_end) begin
                     cnt_q      <= '0;
                     stop_bit_q <= line_i;
                     done_q     <= 1'b1;
                     state_q    <= ST_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign done_o    = done_q;
   assign data_o    = short_i ? (shreg_q >> 1) : shreg_q;
   assign stop_ok_o = stop_bit_q;
   assign par_ok_o  = par_en_i ? ((^data_o ^ par_bit_q) == par_odd_i) : 1'b1;

   // R10
   busy_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> $past(run_i));

   // R2
   bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bits_q <= BIT_W'(DATA_W)));

   // R4
   done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(state_q) == ST_STOP));

endmodule

// File: rtl/srx_status.sv
module srx_status
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done_i,
   input  logic [DATA_W-1:0]    fr_data_i,
   input  logic                 stop_ok_i,
   input  logic                 par_ok_i,
   input  logic                 rd_data_i,
   input  logic                 rd_stat_i,
   input  logic                 wr_stat_i,
   input  logic [NUM_FLAGS-1:0] wr_val_i,
   output logic [DATA_W-1:0]    data_o,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic                 stall_o
);

   logic [DATA_W-1:0]    data_q;
   logic [NUM_FLAGS-1:0] flag_q;
   logic [NUM_FLAGS-1:0] armed;
   logic [NUM_FLAGS-1:0] clr;
   logic [NUM_FLAGS-1:0] set_v;
   logic [NUM_FLAGS-1:0] rd_mask;
   logic                 ready_busy;
   logic                 load;

   assign ready_busy = flag_q[FLAG_RDY] & ~rd_data_i;
   assign load       = done_i & ~ready_busy;
   assign rd_mask    = NUM_FLAGS'(rd_data_i);

   always_comb begin
      set_v           = '0;
      set_v[FLAG_OVR] = done_i & ready_busy;
      set_v[FLAG_FRM] = load & ~stop_ok_i;
      set_v[FLAG_PAR] = load & ~par_ok_i;
      set_v[FLAG_RDY] = load & stop_ok_i & par_ok_i;
   end

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         logic arm_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         arm_q <= 1'b0;
            else if (!flag_q[i]) arm_q <= 1'b0;
            else if (rd_stat_i)  arm_q <= 1'b1;
         end
         assign armed[i] = arm_q;
         assign clr[i]   = wr_stat_i & ~wr_val_i[i] & arm_q;

         if (i != FLAG_RDY) begin : g_err
            // R11
            err_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
               $fell(flag_q[i]) |-> $past(wr_stat_i && !wr_val_i[i]));
         end else begin : g_rdy
            // R7
            ready_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
               $fell(flag_q[i]) |-> $past(rd_data_i || (wr_stat_i && !wr_val_i[i])));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
         data_q <= '0;
      end else begin
         flag_q <= (flag_q & ~clr & ~rd_mask) | set_v;
         if (load) data_q <= fr_data_i;
      end
   end

   assign data_o  = data_q;
   assign flags_o = flag_q;
   assign stall_o = |flag_q[NUM_FLAGS-1:1];

   // R14
   data_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_q != $past(data_q)) |-> $past(done_i));

   // R8
   overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[FLAG_OVR]) |-> $stable(data_q));

   // R6
   ready_needs_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[FLAG_RDY]) |-> ($past(flag_q[NUM_FLAGS-1:1]) == '0));

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
   import srx_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line_i,
   input  logic              rx_en_i,
   input  logic              cfg_short_i,
   input  logic              cfg_par_en_i,
   input  logic              cfg_par_odd_i,
   input  logic              cfg_invert_i,
   input  logic              baud_tick_i,
   input  logic              host_rd_data_i,
   input  logic              host_rd_stat_i,
   input  logic              host_wr_stat_i,
   input  logic [3:0]        host_wr_val_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic [3:0]        rx_status_o
);

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be a power of two of at least 4");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              line_s;
   logic              stall;
   logic              run;
   logic              fr_done;
   logic [DATA_W-1:0] fr_data;
   logic              fr_stop_ok;
   logic              fr_par_ok;

   assign run = rx_en_i & ~stall;

   srx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (rx_line_i),
      .invert_i (cfg_invert_i),
      .line_o   (line_s)
   );

   srx_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (baud_tick_i),
      .line_i    (line_s),
      .run_i     (run),
      .short_i   (cfg_short_i),
      .par_en_i  (cfg_par_en_i),
      .par_odd_i (cfg_par_odd_i),
      .done_o    (fr_done),
      .data_o    (fr_data),
      .stop_ok_o (fr_stop_ok),
      .par_ok_o  (fr_par_ok)
   );

   srx_status #(.DATA_W(DATA_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (fr_done),
      .fr_data_i (fr_data),
      .stop_ok_i (fr_stop_ok),
      .par_ok_i  (fr_par_ok),
      .rd_data_i (host_rd_data_i),
      .rd_stat_i (host_rd_stat_i),
      .wr_stat_i (host_wr_stat_i),
      .wr_val_i  (host_wr_val_i),
      .data_o    (rx_data_o),
      .flags_o   (rx_status_o),
      .stall_o   (stall)
   );

   // R12
   disabled_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rx_en_i) && !$past(host_rd_data_i) && !$past(host_wr_stat_i))
      |-> ($stable(rx_data_o) && $stable(rx_status_o)));

endmodule

// File: tb/test_serial_rx_unit.sv
`timescale 1ns/1ps
module test_serial_rx_unit;

   localparam int TICK_DIV = 3;
   localparam int BIT_CLK  = 16 * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       rx_en = 1'b1;
   logic       cfg_short = 1'b0;
   logic       cfg_par_en = 1'b1;
   logic       cfg_par_odd = 1'b1;
   logic       cfg_invert = 1'b0;
   logic       tick = 1'b0;
   logic       rd_data = 1'b0;
   logic       rd_stat = 1'b0;
   logic       wr_stat = 1'b0;
   logic [3:0] wr_val = 4'hF;
   logic [7:0] rx_data;
   logic [3:0] rx_status;

   int    total = 0;
   int    bad = 0;
   bit    cmp_en = 1'b0;
   string cur_req = "R14";

   logic [7:0] m_data = 8'h00;
   logic [3:0] m_flags = 4'h0;
   logic [3:0] m_armed = 4'h0;

   serial_rx_unit i_serial_rx_unit (
      .clk            (clk),
      .rst_n          (rst_n),
      .rx_line_i      (rx_line),
      .rx_en_i        (rx_en),
      .cfg_short_i    (cfg_short),
      .cfg_par_en_i   (cfg_par_en),
      .cfg_par_odd_i  (cfg_par_odd),
      .cfg_invert_i   (cfg_invert),
      .baud_tick_i    (tick),
      .host_rd_data_i (rd_data),
      .host_rd_stat_i (rd_stat),
      .host_wr_stat_i (wr_stat),
      .host_wr_val_i  (wr_val),
      .rx_data_o      (rx_data),
      .rx_status_o    (rx_status)
   );

   initial forever #2.5 clk = ~clk;

   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         tick = (div == TICK_DIV - 1);
         div  = (div + 1) % TICK_DIV;
      end
   end

   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         total++;
         if (rx_data !== m_data || rx_status !== m_flags) begin
            bad++;
            $display("FAIL %s model: actual data=%02h status=%01h expected data=%02h status=%01h",
                     cur_req, rx_data, rx_status, m_data, m_flags);
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void tidy_arm();
      m_armed = m_armed & m_flags;
   endfunction

   function automatic void m_frame(input logic [7:0] d, input bit stop_ok, input bit par_ok);
      if (!rx_en || m_flags[3:1] != 3'b000) return;
      if (m_flags[0]) begin
         m_flags[1] = 1'b1;
      end else begin
         m_data = d;
         if (!stop_ok) m_flags[2] = 1'b1;
         if (!par_ok)  m_flags[3] = 1'b1;
         if (stop_ok && par_ok) m_flags[0] = 1'b1;
      end
      tidy_arm();
   endfunction

   task automatic drive_bit(input logic b);
      rx_line = b ^ cfg_invert;
      repeat (BIT_CLK) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit stop_v, input bit flip_par, input int gap);
      logic [7:0] dm;
      logic       p;
      int         nb;
      cmp_en = 1'b0;
      nb = cfg_short ? 7 : 8;
      dm = cfg_short ? (d & 8'h7F) : d;
      p  = (^dm) ^ cfg_par_odd ^ flip_par;
      drive_bit(1'b0);
      for (int i = 0; i < nb; i++) drive_bit(d[i]);
      if (cfg_par_en) drive_bit(p);
      drive_bit(stop_v);
      rx_line = 1'b1 ^ cfg_invert;
      m_frame(dm, stop_v, !(cfg_par_en && flip_par));
      if (gap > 0) begin
         repeat (gap) @(negedge clk);
         cmp_en = 1'b1;
      end
   endtask

   task automatic host_read_data();
      rd_data = 1'b1;
      @(posedge clk); #1;
      m_flags[0] = 1'b0;
      tidy_arm();
      @(negedge clk);
      rd_data = 1'b0;
   endtask

   task automatic host_read_stat();
      rd_stat = 1'b1;
      @(posedge clk); #1;
      m_armed = m_armed | m_flags;
      @(negedge clk);
      rd_stat = 1'b0;
   endtask

   task automatic host_write_stat(input logic [3:0] v);
      wr_stat = 1'b1;
      wr_val  = v;
      @(posedge clk); #1;
      for (int i = 0; i < 4; i++)
         if (!v[i] && m_armed[i]) m_flags[i] = 1'b0;
      tidy_arm();
      @(negedge clk);
      wr_stat = 1'b0;
      wr_val  = 4'hF;
   endtask

   task automatic clear_all();
      host_read_stat();
      host_write_stat(4'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R14 reset state
      chk("R14 reset data", rx_data, 8'h00);
      chk("R14 reset status", rx_status, 4'h0);
      cmp_en = 1'b1;

      // R6 R1: clean 8-bit odd-parity character, LSB first
      cur_req = "R6";
      send_frame(8'hA5, 1'b1, 1'b0, 4);
      chk("R6 data", rx_data, 8'hA5);
      chk("R6 ready", rx_status, 4'h1);
      // R7 read of data clears ready
      cur_req = "R7";
      host_read_data();
      chk("R7 ready cleared by read", rx_status, 4'h0);

      // R8 overrun keeps first byte
      cur_req = "R8";
      send_frame(8'h3C, 1'b1, 1'b0, 4);
      send_frame(8'h5A, 1'b1, 1'b0, 4);
      chk("R8 old data kept", rx_data, 8'h3C);
      chk("R8 overrun flag", rx_status, 4'h3);

      // R10 stalled while an error flag is set
      cur_req = "R10";
      send_frame(8'h77, 1'b1, 1'b0, 4);
      chk("R10 stall data", rx_data, 8'h3C);
      chk("R10 stall status", rx_status, 4'h3);

      // R11 write 0 without prior read has no effect
      cur_req = "R11";
      host_write_stat(4'h0);
      chk("R11 unread write ignored", rx_status, 4'h3);
      host_read_stat();
      host_write_stat(4'b1101);
      chk("R11 overrun cleared alone", rx_status, 4'h1);
      // R7 ready cleared by write 0 after read
      cur_req = "R7";
      host_read_stat();
      host_write_stat(4'b1110);
      chk("R7 ready cleared by write", rx_status, 4'h0);

      // R9 R3 parity error still stores data
      cur_req = "R9";
      send_frame(8'h12, 1'b1, 1'b1, 4);
      chk("R9 data stored", rx_data, 8'h12);
      chk("R9 parity flag no ready", rx_status, 4'h8);
      clear_all();
      chk("R11 parity cleared", rx_status, 4'h0);

      // R4 framing error
      cur_req = "R4";
      send_frame(8'h34, 1'b0, 1'b0, 4);
      chk("R4 data stored", rx_data, 8'h34);
      chk("R4 framing flag no ready", rx_status, 4'h4);
      clear_all();

      // R3 even parity
      cur_req = "R3";
      cfg_par_odd = 1'b0;
      send_frame(8'h0F, 1'b1, 1'b0, 4);
      chk("R3 even good", rx_status, 4'h1);
      chk("R3 even data", rx_data, 8'h0F);
      host_read_data();
      send_frame(8'h0F, 1'b1, 1'b1, 4);
      chk("R3 even bad parity", rx_status, 4'h8);
      clear_all();
      cfg_par_en = 1'b0;
      send_frame(8'h81, 1'b1, 1'b0, 4);
      chk("R3 parity disabled data", rx_data, 8'h81);
      chk("R3 parity disabled ready", rx_status, 4'h1);
      host_read_data();

      // R2 seven-bit characters
      cur_req = "R2";
      cfg_par_en = 1'b1;
      cfg_par_odd = 1'b1;
      cfg_short = 1'b1;
      send_frame(8'hD5, 1'b1, 1'b0, 4);
      chk("R2 bit7 zero", rx_data, 8'h55);
      chk("R2 ready", rx_status, 4'h1);
      host_read_data();
      cfg_short = 1'b0;

      // R1 glitch shorter than half a bit
      cur_req = "R1";
      rx_line = 1'b0;
      repeat (3 * TICK_DIV) @(negedge clk);
      rx_line = 1'b1;
      repeat (2 * BIT_CLK) @(negedge clk);
      chk("R1 glitch status", rx_status, 4'h0);
      chk("R1 glitch data", rx_data, 8'h55);
      send_frame(8'h96, 1'b1, 1'b0, 4);
      chk("R1 LSB first", rx_data, 8'h96);
      host_read_data();

      // R5 start right after stop
      cur_req = "R5";
      fork
         begin
            send_frame(8'h11, 1'b1, 1'b0, 0);
            send_frame(8'h22, 1'b1, 1'b0, 4);
         end
         begin
            repeat (BIT_CLK * 11 + 100) @(negedge clk);
            chk("R5 first char", rx_data, 8'h11);
            host_read_data();
         end
      join
      chk("R5 second char", rx_data, 8'h22);
      chk("R5 second ready", rx_status, 4'h1);
      host_read_data();

      // R12 disable keeps flags and ignores line
      cur_req = "R12";
      send_frame(8'hC3, 1'b0, 1'b0, 4);
      rx_en = 1'b0;
      repeat (10) @(negedge clk);
      chk("R12 flag kept", rx_status, 4'h4);
      chk("R12 data kept", rx_data, 8'hC3);
      clear_all();
      send_frame(8'h99, 1'b1, 1'b0, 4);
      chk("R12 frame ignored data", rx_data, 8'hC3);
      chk("R12 frame ignored status", rx_status, 4'h0);
      rx_en = 1'b1;

      // R13 inverted line
      cur_req = "R13";
      cfg_invert = 1'b1;
      rx_line = 1'b0;
      repeat (2 * BIT_CLK) @(negedge clk);
      send_frame(8'h6B, 1'b1, 1'b0, 4);
      chk("R13 inverted data", rx_data, 8'h6B);
      chk("R13 inverted ready", rx_status, 4'h1);

      repeat (20) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule